// File: doc/BRIEF.md
# Programmable-Burst DMA Request Controller

This block drives the request side of the handshake between an external DMA engine and an on-chip buffer RAM. Software loads a mode, a burst value and a transfer length, then pulses a start input. The block raises a request and watches the acknowledge and the per-cycle read/write completion strobe. For each completed cycle it gives one transfer strobe to the address pointer logic. It ends the transfer on a terminal-count condition. At the end it clears its own active state and latches a done event, which drives a maskable interrupt.

Four transfer modes are selected by `mode_i`. In single mode there is one request per cycle. Continuous mode holds the request until the end. Cycle-gated burst mode drops the request after a programmed number of completed cycles. Time-gated burst mode drops the request after a programmed number of clocks. In both gated modes the request stays low for a fixed gate interval and then comes back. A falling edge on the refresh-execution input forces the request low for a fixed refresh interval in any mode. This leaves the external bus free for memory refresh. The polarities of the request pin and the terminal-count pin are each programmable.

All pins are plain control and status signals. No data path crosses this block, so it has no valid/ready interface and no back-pressure. Flow control is the request/acknowledge pair itself.

Top module: `dma_burst_req`

## Requirements
- R1: `dreq_o` carries the internal request at the level chosen by `req_pol_i`: with 1 it is active high, with 0 it is active low. While the block is not active, `dreq_o` sits at the inactive level, which is `!req_pol_i`. After reset the block is not active.
- R2: Mode 2'b00 (single). After a completed cycle, the request is inactive from the next clock. It stays inactive while `dack_n_i` is still low. It is active again the clock after `dack_n_i` is sampled high.
- R3: Mode 2'b01 (continuous). The request stays active on every clock until the transfer ends, whatever the completion strobes do.
- R4: Mode 2'b10 (cycle-gated burst). The request stays active for exactly N completed cycles. It is then inactive for exactly GATE_CYCLES clocks and then becomes active again. N is `burst_val_i`.
- R5: Mode 2'b11 (time-gated burst). The request is active for exactly N clocks, then inactive for exactly GATE_CYCLES clocks, then active again.
- R6: A `burst_val_i` of zero means N = 256 in both gated modes.
- R7: With `int_tc_en_i` = 0, the transfer ends on a completed cycle during which `tc_i` equals `tc_pol_i` (the active level). An active `tc_i` without a completed cycle does not end it, and neither does a completed cycle with `tc_i` inactive.
- R8: With `int_tc_en_i` = 1, the transfer ends on the L-th completed cycle, where L is `xfer_len_i` (0 counts as 1). `tc_i` has no effect.
- R9: A high-to-low transition of `refex_n_i` during a transfer makes the request inactive from the next clock for exactly REFRESH_CYCLES clocks. A steady low level has no further effect.
- R10: When the transfer ends, `active_o` falls on the next clock and a done event is latched. `done_irq_o` shows the latched event gated by `irq_mask_i`, and the next start clears it.
- R11: `xfer_stb_o` is high exactly when the block is active, `dack_n_i` is low and `rw_done_i` is high. A completion strobe while acknowledge is inactive neither pulses it nor counts toward any limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Start pulse, taken while idle |
| mode_i | input | 2 | 00 single, 01 continuous, 10 cycle-gated, 11 time-gated |
| req_pol_i | input | 1 | 1: request active high, 0: active low |
| tc_pol_i | input | 1 | Active level of `tc_i` |
| int_tc_en_i | input | 1 | 1: end on internal length count, 0: end on `tc_i` |
| xfer_len_i | input | LEN_W | Transfer length in cycles for internal count |
| burst_val_i | input | BURST_W | Burst cycles or clocks, zero means 256 |
| irq_mask_i | input | 1 | 1 masks the done interrupt |
| dack_n_i | input | 1 | DMA acknowledge, active low |
| rw_done_i | input | 1 | One-clock pulse per completed read/write cycle |
| tc_i | input | 1 | External terminal count |
| refex_n_i | input | 1 | Refresh execution, acted on at its falling edge |
| dreq_o | output | 1 | DMA request at programmed polarity |
| active_o | output | 1 | Transfer in progress (DMA enable state) |
| done_irq_o | output | 1 | Done interrupt, level |
| xfer_stb_o | output | 1 | One pulse per completed cycle to the pointer logic |

## Verification
A wrong count in the burst or gate counter shows as a request high or low time that is off by one or more clocks. It appears at the first burst after start, so the bench measures both phases in clocks over every small burst value and over the zero-means-256 case. A terminal-length counter that is wrong shows as `active_o` falling one strobe early or late, and a stuck done latch shows at the very next start. A faulty edge detector either misses the refresh window or repeats it while the pin is held low, and either fault is visible at `dreq_o` within a few clocks.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE  = 2'd0,
    MODE_CONT    = 2'd1,
    MODE_CYCGATE = 2'd2,
    MODE_TIMGATE = 2'd3
  } xfer_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_HOLD = 3'd2,
    ST_GATE = 3'd3,
    ST_REFR = 3'd4
  } req_state_e;

endpackage

// File: rtl/dmareq_downcnt.sv
module dmareq_downcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 count <= '0;
    else if (load)              count <= load_val;
    else if (dec && count != '0) count <= count - W'(1);
  end

  // counter moves by at most one step when not loaded
  p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && dec && count != '0) |=> (count == $past(count) - W'(1)));

endmodule

// File: rtl/dmareq_pinsync.sv
module dmareq_pinsync (
  input  logic clk,
  input  logic rst_n,
  input  logic refex_n_i,
  input  logic tc_i,
  input  logic tc_pol_i,
  output logic ref_fall,
  output logic tc_act
);

  logic refex_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) refex_q <= 1'b1;
    else        refex_q <= refex_n_i;
  end

  assign ref_fall = refex_q & ~refex_n_i;
  assign tc_act   = tc_pol_i ? tc_i : ~tc_i;

  // a held low level yields only one edge event
  p_edge_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_fall && !refex_n_i) |=> (!ref_fall || $rose(refex_q)));

endmodule

// File: rtl/dmareq_fsm.sv
module dmareq_fsm
  import dmareq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  xfer_mode_e mode,
  input  logic       go,
  input  logic       fin,
  input  logic       ref_fall,
  input  logic       xfer,
  input  logic       dack_n,
  input  logic       burst_last,
  input  logic       wait_last,
  output req_state_e state,
  output logic       ld_burst,
  output logic       dec_burst,
  output logic       ld_gate,
  output logic       ld_refr,
  output logic       dec_wait
);

  req_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (go) nxt = ST_REQ;
      ST_REQ: begin
        unique case (mode)
          MODE_SINGLE:  if (xfer) nxt = ST_HOLD;
          MODE_CYCGATE: if (xfer && burst_last) nxt = ST_GATE;
          MODE_TIMGATE: if (burst_last) nxt = ST_GATE;
          default:      nxt = ST_REQ;
        endcase
      end
      ST_HOLD: if (dack_n) nxt = ST_REQ;
      ST_GATE, ST_REFR: if (wait_last) nxt = ST_REQ;
      default: nxt = ST_IDLE;
    endcase
    if (state != ST_IDLE) begin
      if (fin)           nxt = ST_IDLE;
      else if (ref_fall) nxt = ST_REFR;
    end
  end

  assign ld_burst  = (nxt == ST_REQ) && (state != ST_REQ);
  assign ld_gate   = (nxt == ST_GATE) && (state != ST_GATE);
  assign ld_refr   = (state != ST_IDLE) && !fin && ref_fall;
  assign dec_wait  = (state == ST_GATE) || (state == ST_REFR);
  assign dec_burst = (state == ST_REQ) &&
                     ((mode == MODE_TIMGATE) || ((mode == MODE_CYCGATE) && xfer));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  // single mode: no return to request while acknowledge is still low
  p_hold_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && !dack_n && !fin && !ref_fall) |=> (state != ST_REQ));

endmodule

// File: rtl/dma_burst_req.sv
module dma_burst_req
  import dmareq_pkg::*;
#(
  parameter int LEN_W          = 16,
  parameter int BURST_W        = 8,
  parameter int GATE_CYCLES    = 16,
  parameter int REFRESH_CYCLES = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_i,
  input  logic [1:0]         mode_i,
  input  logic               req_pol_i,
  input  logic               tc_pol_i,
  input  logic               int_tc_en_i,
  input  logic [LEN_W-1:0]   xfer_len_i,
  input  logic [BURST_W-1:0] burst_val_i,
  input  logic               irq_mask_i,
  input  logic               dack_n_i,
  input  logic               rw_done_i,
  input  logic               tc_i,
  input  logic               refex_n_i,
  output logic               dreq_o,
  output logic               active_o,
  output logic               done_irq_o,
  output logic               xfer_stb_o
);

  localparam int BCNT_W   = BURST_W + 1;
  localparam int WAIT_MAX = (GATE_CYCLES > REFRESH_CYCLES) ? GATE_CYCLES : REFRESH_CYCLES;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

  req_state_e        state;
  xfer_mode_e        mode;
  logic              ref_fall, tc_act, xfer, fin, req_int, done_q;
  logic              ld_burst, dec_burst, ld_gate, ld_refr, dec_wait;
  logic [LEN_W-1:0]  term_cnt;
  logic [BCNT_W-1:0] burst_cnt, burst_ld;
  logic [WAIT_W-1:0] wait_cnt, wait_ld;

  assign mode     = xfer_mode_e'(mode_i);
  assign active_o = (state != ST_IDLE);
  assign req_int  = (state == ST_REQ);
  assign xfer     = active_o & ~dack_n_i & rw_done_i;
  assign xfer_stb_o = xfer;
  assign dreq_o   = req_pol_i ? req_int : ~req_int;

  assign fin = int_tc_en_i ? (xfer && term_cnt <= LEN_W'(1))
                           : (xfer && tc_act);

  assign burst_ld = (burst_val_i == '0) ? BCNT_W'(2 ** BURST_W) : BCNT_W'(burst_val_i);
  assign wait_ld  = ld_refr ? WAIT_W'(REFRESH_CYCLES) : WAIT_W'(GATE_CYCLES);

  dmareq_pinsync u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .refex_n_i (refex_n_i),
    .tc_i      (tc_i),
    .tc_pol_i  (tc_pol_i),
    .ref_fall  (ref_fall),
    .tc_act    (tc_act)
  );

  dmareq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .go         (go_i),
    .fin        (fin),
    .ref_fall   (ref_fall),
    .xfer       (xfer),
    .dack_n     (dack_n_i),
    .burst_last (burst_cnt == BCNT_W'(1)),
    .wait_last  (wait_cnt == WAIT_W'(1)),
    .state      (state),
    .ld_burst   (ld_burst),
    .dec_burst  (dec_burst),
    .ld_gate    (ld_gate),
    .ld_refr    (ld_refr),
    .dec_wait   (dec_wait)
  );

  dmareq_downcnt #(.W(LEN_W)) u_term (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (go_i && !active_o),
    .load_val (xfer_len_i),
    .dec      (xfer && int_tc_en_i),
    .count    (term_cnt)
  );

  dmareq_downcnt #(.W(BCNT_W)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld_burst),
    .load_val (burst_ld),
    .dec      (dec_burst),
    .count    (burst_cnt)
  );

  dmareq_downcnt #(.W(WAIT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld_gate || ld_refr),
    .load_val (wait_ld),
    .dec      (dec_wait),
    .count    (wait_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  done_q <= 1'b0;
    else if (fin)                done_q <= 1'b1;
    else if (go_i && !active_o)  done_q <= 1'b0;
  end

  assign done_irq_o = done_q & ~irq_mask_i;

  p_idle_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> (dreq_o == !req_pol_i));

  p_cont_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CONT && req_int && !fin && !ref_fall) |=> req_int);

  p_single_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SINGLE && req_int && xfer && !fin && !ref_fall) |=> !req_int);

  p_refresh_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_fall && active_o && !fin) |=> !req_int);

  p_finish_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (!active_o && done_q));

endmodule

// File: tb/dma_burst_req_tb.sv
module dma_burst_req_tb;

  localparam int GATE = 3;
  localparam int REFR = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       go = 1'b0;
  logic [1:0] mode = 2'd1;
  logic       req_pol = 1'b1, tc_pol = 1'b1, int_tc = 1'b0;
  logic [7:0] xlen = 8'd1, bval = 8'd1;
  logic       mask = 1'b0, dack_n = 1'b1, rw = 1'b0, tc = 1'b0, refex_n = 1'b1;
  logic       dreq, active, irq, stb;

  int checks = 0, errors = 0, hi = 0, lo = 0, n = 0, expn = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_burst_req #(.LEN_W(8), .BURST_W(8), .GATE_CYCLES(GATE), .REFRESH_CYCLES(REFR)) u_dut (
    .clk(clk), .rst_n(rst_n), .go_i(go), .mode_i(mode), .req_pol_i(req_pol),
    .tc_pol_i(tc_pol), .int_tc_en_i(int_tc), .xfer_len_i(xlen), .burst_val_i(bval),
    .irq_mask_i(mask), .dack_n_i(dack_n), .rw_done_i(rw), .tc_i(tc), .refex_n_i(refex_n),
    .dreq_o(dreq), .active_o(active), .done_irq_o(irq), .xfer_stb_o(stb)
  );

  task automatic step;
    @(posedge clk); #1;
  endtask

  function automatic bit req_on;
    return dreq == req_pol;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start(input logic [1:0] m);
    mode = m; go = 1'b1; step; go = 1'b0;
  endtask

  task automatic finish_ext;
    dack_n = 1'b0; rw = 1'b1; tc = tc_pol; step;
    rw = 1'b0; dack_n = 1'b1; tc = ~tc_pol;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog all-requirements actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step;
    rst_n = 1'b1; step;
    // R1 reset state
    chk(dreq == 1'b0 && !active && !irq, "R1 reset", dreq, 0);

    // R1 polarity sweep
    for (int p = 0; p < 2; p++) begin
      req_pol = p[0]; tc = ~tc_pol; step;
      chk(dreq == !req_pol, "R1 idle level", dreq, !req_pol);
      start(2'd1);
      chk(dreq == req_pol, "R1 active level", dreq, req_pol);
      finish_ext; step;
      chk(dreq == !req_pol, "R1 level after end", dreq, !req_pol);
    end

    // R2 single mode
    start(2'd0);
    for (int r = 0; r < 3; r++) begin
      chk(req_on(), "R2 request up", dreq, req_pol);
      dack_n = 1'b0; rw = 1'b1; step; rw = 1'b0;
      chk(!req_on(), "R2 drop after cycle", dreq, !req_pol);
      step; step;
      chk(!req_on(), "R2 low while ack held", dreq, !req_pol);
      dack_n = 1'b1; step;
      chk(req_on(), "R2 back after ack release", dreq, req_pol);
    end
    finish_ext; step;

    // R3 continuous
    start(2'd1);
    hi = 0;
    for (int c = 0; c < 40; c++) begin
      dack_n = 1'b0; rw = c[0]; step;
      if (req_on()) hi++;
    end
    rw = 1'b0;
    chk(hi == 40, "R3 held for 40 clocks", hi, 40);
    finish_ext; step;
    chk(!active, "R3 ends on tc", active, 0);

    // R4/R6 cycle-gated sweep
    for (int k = 0; k < 7; k++) begin
      n = (k == 6) ? 0 : k + 1;
      expn = (n == 0) ? 256 : n;
      bval = n[7:0];
      start(2'd2);
      dack_n = 1'b0;
      hi = 0;
      while (req_on() && hi < 400) begin rw = 1'b1; step; hi++; end
      rw = 1'b0;
      lo = 0;
      while (!req_on() && lo < 400) begin step; lo++; end
      chk(hi == expn, (n == 0) ? "R6 cycle burst zero" : "R4 cycle burst length", hi, expn);
      chk(lo == GATE, "R4 gate length", lo, GATE);
      finish_ext; step;
    end

    // R5/R6 time-gated sweep
    for (int k = 0; k < 7; k++) begin
      n = (k == 6) ? 0 : k + 1;
      expn = (n == 0) ? 256 : n;
      bval = n[7:0];
      start(2'd3);
      hi = 0;
      while (req_on() && hi < 400) begin step; hi++; end
      lo = 0;
      while (!req_on() && lo < 400) begin step; lo++; end
      chk(hi == expn, (n == 0) ? "R6 timer burst zero" : "R5 timer burst length", hi, expn);
      chk(lo == GATE, "R5 gate length", lo, GATE);
      finish_ext; step;
    end

    // R7 external terminal count, both polarities; R11 strobe needs ack
    int_tc = 1'b0;
    for (int p = 0; p < 2; p++) begin
      tc_pol = p[0];
      start(2'd1);
      tc = tc_pol; dack_n = 1'b1; rw = 1'b1; #1;
      chk(!stb, "R11 no strobe without ack", stb, 0);
      step;
      chk(active, "R7 tc without cycle ignored", active, 1);
      tc = ~tc_pol; dack_n = 1'b0; rw = 1'b1; #1;
      chk(stb, "R11 strobe with ack", stb, 1);
      step;
      chk(active, "R7 cycle without tc continues", active, 1);
      tc = tc_pol; step; rw = 1'b0; dack_n = 1'b1; tc = ~tc_pol;
      chk(!active && !req_on(), "R7 end on tc with cycle", active, 0);
    end
    tc_pol = 1'b1; tc = 1'b0;

    // R8 internal length, tc held active; R11 unacked strobe not counted
    int_tc = 1'b1; tc = 1'b1;
    for (int len = 1; len <= 5; len++) begin
      xlen = len[7:0];
      start(2'd1);
      dack_n = 1'b1; rw = 1'b1; step; rw = 1'b0;
      n = 0;
      while (active && n < 50) begin dack_n = 1'b0; rw = 1'b1; step; n++; end
      rw = 1'b0; dack_n = 1'b1;
      chk(n == len, "R8 internal length", n, len);
    end
    int_tc = 1'b0; tc = 1'b0;

    // R9 refresh window
    start(2'd1);
    refex_n = 1'b1; step;
    refex_n = 1'b0; step;
    lo = 0;
    while (!req_on() && lo < 50) begin step; lo++; end
    chk(lo == REFR, "R9 refresh low time", lo, REFR);
    step; step; step;
    chk(req_on(), "R9 held low level no effect", dreq, req_pol);
    refex_n = 1'b1;
    finish_ext; step;

    // R10 done interrupt and mask
    chk(irq, "R10 done raised", irq, 1);
    start(2'd1);
    chk(!irq, "R10 start clears done", irq, 1'b0);
    mask = 1'b1;
    finish_ext; step;
    chk(!irq && !active, "R10 masked done", irq, 0);
    mask = 1'b0; #1;
    chk(irq, "R10 unmasked done", irq, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule